// File: doc/BRIEF.md
# I2C Target Protocol Engine

This block is the target (slave) side of a two-wire I2C link. It receives the open-drain clock and data lines, brings them into the system clock domain, and finds start and stop conditions and bit boundaries. After a start it collects an address byte. If the upper seven bits match the `own_addr` input, it acknowledges the address and runs a write session or a read session. The direction bit, the least significant bit of the address byte, selects which one.

In a write session, every received byte goes to the user logic through a one-cycle `rx_valid` strobe. The user logic answers in that same cycle with `rx_accept`. An accepted byte is acknowledged. A refused byte is left unacknowledged, and the engine drops off the bus until the next start. In a read session, the engine asks the user logic for each byte through a one-cycle `tx_req` strobe and shifts the byte out MSB first. The controller's acknowledge bit after each byte decides whether a further byte is fetched. The only drive the engine puts on the bus is an open-drain enable that pulls SDA low.

The state machine has seven named states:
- `ST_IDLE`: off the bus, waiting for a start.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: driving the address acknowledge.
- `ST_RX_BYTE`: shifting in a written byte.
- `ST_RX_ACK`: driving the acknowledge for an accepted byte.
- `ST_TX_BYTE`: shifting out a read byte.
- `ST_TX_ACKCHK`: sampling the controller's acknowledge.

The transitions are as follows:
- A start moves any state to `ST_ADDR`.
- A stop moves any state to `ST_IDLE`.
- `ST_ADDR` moves to `ST_ADDR_ACK` on a match, or to `ST_IDLE` on a mismatch.
- From `ST_ADDR_ACK`, a write goes to `ST_RX_BYTE`. A read goes to `ST_TX_BYTE` when a byte is supplied, or to `ST_IDLE` when it is declined.
- `ST_RX_BYTE` moves to `ST_RX_ACK` on accept, or to `ST_IDLE` on refuse.
- `ST_RX_ACK` returns to `ST_RX_BYTE`.
- `ST_TX_BYTE` moves to `ST_TX_ACKCHK` after eight bits.
- `ST_TX_ACKCHK` moves to `ST_TX_BYTE` on an ACK with a byte supplied, or to `ST_IDLE` on a NACK or a declined byte.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset, `sda_oe` is 0 (SDA released) and none of `sess_start`, `sess_stop`, `rx_valid` or `tx_req` is asserted.
- R2: SDA falling while SCL is high is a start. It moves the engine to address collection from any state. SDA rising while SCL is high is a stop. It moves the engine to idle from any state. When either one ends an open session, `sess_stop` pulses for one cycle.
- R3: A bit is taken from SDA on a falling SCL edge only if a rising SCL edge came before it. The SCL fall that follows a start is not a bit. Bytes are assembled MSB first.
- R4: An address byte whose bits [7:1] equal `own_addr` is acknowledged: SDA is held low through the ninth clock. `sess_start` then pulses, with `sess_is_read` equal to bit 0 (1 = read). On a mismatch there is no acknowledge, and the engine ignores all bits until the next start.
- R5: In a write session, each received byte appears on `rx_data` during a one-cycle `rx_valid`. If `rx_accept` is 1 in that cycle, the byte is acknowledged.
- R6: If `rx_accept` is 0 during `rx_valid`, the byte is not acknowledged, `sess_stop` pulses, and every later bit is ignored until the next start.
- R7: In a read session, `tx_req` pulses at the SCL fall that ends the address-acknowledge clock. `tx_data` is taken in the cycle where `tx_req` and `tx_valid` are both 1. It is shifted out MSB first, each bit set up after an SCL fall.
- R8: After each read byte, a controller ACK (0) causes the next `tx_req`. A NACK (1) releases SDA, returns the engine to idle and pulses `sess_stop`.
- R9: If `tx_valid` is 0 while `tx_req` is 1, SDA stays released, the engine returns to idle and `sess_stop` pulses.
- R10: `sda_oe` changes only while SCL is low, and it is 1 only while the engine drives an ACK or a 0 data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| own_addr | input | 7 | Seven-bit target address |
| sess_start | output | 1 | One-cycle pulse after the address is acknowledged |
| sess_is_read | output | 1 | Direction of the current session, 1 = read |
| sess_stop | output | 1 | One-cycle pulse when a session ends |
| rx_data | output | 8 | Received byte, valid with rx_valid |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_accept | input | 1 | Accept (1) or refuse (0) the strobed byte |
| tx_req | output | 1 | One-cycle request for the next read byte |
| tx_valid | input | 1 | User supplies a byte in the tx_req cycle |
| tx_data | input | 8 | Byte to transmit, taken with tx_req and tx_valid |

## Verification
The assertions assume that the controller holds SCL low for longer than the synchronizer and edge-detection latency. This guarantees that every change the engine makes to `sda_oe` lands while SCL is still low. They also assume the controller never changes SDA while SCL is high except to signal a start or a stop, and that the user side answers `rx_valid` and `tx_req` in the same cycle. The bench meets these assumptions with a bit-level controller model whose SCL quarter-period spans six system clocks, with SDA changed only mid-low. Accept and supply levels are set up before each session. Random session directions, lengths and payloads come from a fixed seed.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_BYTE,
        ST_RX_ACK,
        ST_TX_BYTE,
        ST_TX_ACKCHK
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_p, sda_p, scl_s;

    // Bus idles high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // SDA edge while SCL has been high on both samples: bus condition
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rx_accept,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              sda_oe,
    output logic              sess_start,
    output logic              sess_is_read,
    output logic              sess_stop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_req,
    output tgt_state_t        state
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    tgt_state_t        state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BYTE_W-1:0] sh, sh_n, sh_in;
    logic              oe_n, rd, rd_n, in_bit, in_bit_n;
    logic              start_q, start_c, bit_evt, active;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            sda_oe  <= 1'b0;
            rd      <= 1'b0;
            in_bit  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            sh      <= sh_n;
            sda_oe  <= oe_n;
            rd      <= rd_n;
            in_bit  <= in_bit_n;
            start_q <= start_c;
        end
    end

    assign sh_in   = {sh[BYTE_W-2:0], sda_s};
    assign bit_evt = scl_fall & in_bit;
    assign active  = (state != ST_IDLE) && (state != ST_ADDR);

    always_comb begin
        in_bit_n = in_bit;
        if (start_det || stop_det || scl_fall) in_bit_n = 1'b0;
        else if (scl_rise)                     in_bit_n = 1'b1;
    end

    // Next-state and output logic
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        sh_n      = sh;
        oe_n      = sda_oe;
        rd_n      = rd;
        start_c   = 1'b0;
        sess_stop = 1'b0;
        rx_valid  = 1'b0;
        tx_req    = 1'b0;
        if (start_det) begin
            sess_stop = active;
            state_n   = ST_ADDR;
            cnt_n     = '0;
            oe_n      = 1'b0;
        end else if (stop_det) begin
            sess_stop = active;
            state_n   = ST_IDLE;
            oe_n      = 1'b0;
        end else if (bit_evt) begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    sh_n  = sh_in;
                    cnt_n = cnt + 1'b1;
                    if (cnt == LAST) begin
                        cnt_n = '0;
                        if (sh_in[BYTE_W-1:1] == own_addr) begin
                            start_c = 1'b1;
                            rd_n    = sh_in[0];
                            oe_n    = 1'b1;
                            state_n = ST_ADDR_ACK;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    oe_n  = 1'b0;
                    cnt_n = '0;
                    if (rd) begin
                        tx_req = 1'b1;
                        if (tx_valid) begin
                            sh_n    = tx_data;
                            oe_n    = ~tx_data[BYTE_W-1];
                            state_n = ST_TX_BYTE;
                        end else begin
                            sess_stop = 1'b1;
                            state_n   = ST_IDLE;
                        end
                    end else begin
                        state_n = ST_RX_BYTE;
                    end
                end
                ST_RX_BYTE: begin
                    sh_n  = sh_in;
                    cnt_n = cnt + 1'b1;
                    if (cnt == LAST) begin
                        cnt_n    = '0;
                        rx_valid = 1'b1;
                        if (rx_accept) begin
                            oe_n    = 1'b1;
                            state_n = ST_RX_ACK;
                        end else begin
                            sess_stop = 1'b1;
                            state_n   = ST_IDLE;
                        end
                    end
                end
                ST_RX_ACK: begin
                    oe_n    = 1'b0;
                    cnt_n   = '0;
                    state_n = ST_RX_BYTE;
                end
                ST_TX_BYTE: begin
                    if (cnt == LAST) begin
                        oe_n    = 1'b0;
                        cnt_n   = '0;
                        state_n = ST_TX_ACKCHK;
                    end else begin
                        sh_n  = {sh[BYTE_W-2:0], 1'b1};
                        oe_n  = ~sh[BYTE_W-2];
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_TX_ACKCHK: begin
                    if (!sda_s) begin
                        tx_req = 1'b1;
                        if (tx_valid) begin
                            sh_n    = tx_data;
                            oe_n    = ~tx_data[BYTE_W-1];
                            state_n = ST_TX_BYTE;
                        end else begin
                            sess_stop = 1'b1;
                            state_n   = ST_IDLE;
                        end
                    end else begin
                        sess_stop = 1'b1;
                        state_n   = ST_IDLE;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    assign sess_start   = start_q;
    assign sess_is_read = rd;
    assign rx_data      = sh_in;
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              sess_start,
    output logic              sess_is_read,
    output logic              sess_stop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_accept,
    output logic              tx_req,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    tgt_state_t state;

    i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sda_s        (sda_s),
        .own_addr     (own_addr),
        .rx_accept    (rx_accept),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .sda_oe       (sda_oe),
        .sess_start   (sess_start),
        .sess_is_read (sess_is_read),
        .sess_stop    (sess_stop),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .tx_req       (tx_req),
        .state        (state)
    );
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       rx_valid,
    input logic       rx_accept,
    input logic       tx_req,
    input logic       tx_valid,
    input logic       start_det,
    input logic       stop_det,
    input logic       sess_stop,
    input tgt_state_t state
);
    p_start_to_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR) && !sda_oe);

    p_stop_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_oe);

    p_accept_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_accept && !start_det && !stop_det) |=> sda_oe);

    p_refuse_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_accept) |-> sess_stop ##1 ((state == ST_IDLE) && !sda_oe));

    p_decline_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_valid) |-> sess_stop ##1 ((state == ST_IDLE) && !sda_oe));

    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    p_strobes_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && tx_req));
endmodule

bind i2c_target_engine i2c_tgt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .rx_valid  (rx_valid),
    .rx_accept (rx_accept),
    .tx_req    (tx_req),
    .tx_valid  (tx_valid),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sess_stop (sess_stop),
    .state     (state)
);

// File: tb/test_i2c_target_engine.sv
module test_i2c_target_engine;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam logic [6:0] MY_ADDR = 7'h52;

    logic clk = 0, rst_n = 0;
    logic scl_low = 0, sda_low = 0;
    logic scl_i, sda_i, sda_oe;
    logic sess_start, sess_is_read, sess_stop, rx_valid, tx_req;
    logic rx_accept = 1, tx_valid = 1;
    logic [7:0] rx_data, tx_data;
    int checks = 0, fails = 0;
    int rx_n = 0, start_n = 0, stop_n = 0, tx_cnt = 0, r10_viol = 0;
    logic last_dir = 0, oe_prev = 0;
    logic [7:0] rx_log [0:63];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign scl_i = ~scl_low;
    assign sda_i = ~(sda_low | sda_oe);

    function automatic logic [7:0] tx_pat(input int n);
        return 8'((n * 29) ^ 8'hA7);
    endfunction
    assign tx_data = tx_pat(tx_cnt);

    i2c_target_engine i_i2c_target_engine (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
        .own_addr(MY_ADDR), .sess_start(sess_start), .sess_is_read(sess_is_read),
        .sess_stop(sess_stop), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_accept(rx_accept), .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    always @(posedge clk) if (tx_req) tx_cnt <= tx_cnt + 1;

    always @(negedge clk) begin
        if (rx_valid) begin rx_log[rx_n % 64] = rx_data; rx_n++; end
        if (sess_start) begin start_n++; last_dir = sess_is_read; end
        if (sess_stop) stop_n++;
        if (rst_n && (sda_oe !== oe_prev) && scl_i) r10_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q;
        repeat (Q) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic s);
        sda_low = !b; wait_q;
        scl_low = 0;  wait_q;
        s = sda_i;    wait_q;
        scl_low = 1;  wait_q;
    endtask

    task automatic bus_start;
        sda_low = 0; wait_q;
        scl_low = 0; wait_q;
        sda_low = 1; wait_q;
        scl_low = 1; wait_q;
    endtask

    task automatic bus_stop;
        sda_low = 1; wait_q;
        scl_low = 0; wait_q;
        sda_low = 0; wait_q;
    endtask

    task automatic write_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(d[i], s);
        send_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin send_bit(1'b1, s); d = {d[6:0], s}; end
        send_bit(!ack, s);
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        int s0, r0, c0, st0, len;
        logic dir;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk("R1 oe after reset", 32'(sda_oe), 0);
        chk("R1 strobes after reset", 32'({sess_start, sess_stop, rx_valid, tx_req}), 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R1 oe idle", 32'(sda_oe), 0);

        // Directed write, three accepted bytes
        rx_accept = 1; st0 = stop_n; r0 = rx_n;
        bus_start;
        write_byte({MY_ADDR, 1'b0}, a);
        chk("R4 address ack", 32'(a), 1);
        chk("R4 sess_start count", 32'(start_n), 1);
        chk("R4 direction write", 32'(last_dir), 0);
        write_byte(8'h80, a); chk("R5 ack byte0", 32'(a), 1);
        write_byte(8'h01, a); chk("R5 ack byte1", 32'(a), 1);
        write_byte(8'hC3, a); chk("R5 ack byte2", 32'(a), 1);
        chk("R3 rx count", 32'(rx_n - r0), 3);
        chk("R3 byte0 msb first", 32'(rx_log[r0 % 64]), 32'h80);
        chk("R3 byte1 lsb", 32'(rx_log[(r0 + 1) % 64]), 32'h01);
        chk("R3 byte2", 32'(rx_log[(r0 + 2) % 64]), 32'hC3);
        bus_stop;
        chk("R2 stop pulse", 32'(stop_n - st0), 1);

        // Mismatched address ignored
        s0 = start_n; r0 = rx_n; st0 = stop_n;
        bus_start;
        write_byte({7'h53, 1'b0}, a);
        chk("R4 mismatch no ack", 32'(a), 0);
        write_byte(8'h11, a);
        chk("R4 mismatch byte no ack", 32'(a), 0);
        chk("R4 mismatch no rx", 32'(rx_n - r0), 0);
        chk("R4 mismatch no start", 32'(start_n - s0), 0);
        bus_stop;
        chk("R4 mismatch no stop pulse", 32'(stop_n - st0), 0);

        // Refused write
        rx_accept = 0; st0 = stop_n;
        bus_start;
        write_byte({MY_ADDR, 1'b0}, a);
        chk("R6 address ack", 32'(a), 1);
        write_byte(8'h3C, a);
        chk("R6 refused byte no ack", 32'(a), 0);
        chk("R6 stop pulse on refuse", 32'(stop_n - st0), 1);
        r0 = rx_n;
        write_byte(8'h99, a);
        chk("R6 later byte no ack", 32'(a), 0);
        chk("R6 later byte ignored", 32'(rx_n - r0), 0);
        bus_stop;
        chk("R6 no second stop pulse", 32'(stop_n - st0), 1);
        rx_accept = 1;

        // Directed read, ACK two, NACK third
        tx_valid = 1; st0 = stop_n; c0 = tx_cnt;
        bus_start;
        write_byte({MY_ADDR, 1'b1}, a);
        chk("R4 read address ack", 32'(a), 1);
        chk("R4 direction read", 32'(last_dir), 1);
        chk("R7 first request after ack", 32'(tx_cnt - c0), 1);
        read_byte(1'b1, d); chk("R7 read byte0", 32'(d), 32'(tx_pat(c0)));
        read_byte(1'b1, d); chk("R8 read byte1", 32'(d), 32'(tx_pat(c0 + 1)));
        read_byte(1'b0, d); chk("R8 read byte2", 32'(d), 32'(tx_pat(c0 + 2)));
        chk("R8 request count", 32'(tx_cnt - c0), 3);
        chk("R8 nack stop pulse", 32'(stop_n - st0), 1);
        chk("R8 released after nack", 32'(sda_oe), 0);
        bus_stop;
        chk("R8 idle stop no pulse", 32'(stop_n - st0), 1);

        // Declined read
        tx_valid = 0; st0 = stop_n;
        bus_start;
        write_byte({MY_ADDR, 1'b1}, a);
        chk("R9 address ack", 32'(a), 1);
        chk("R9 stop pulse on decline", 32'(stop_n - st0), 1);
        read_byte(1'b0, d);
        chk("R9 bus released", 32'(d), 32'hFF);
        bus_stop;
        tx_valid = 1;

        // Repeated start during a write session
        st0 = stop_n;
        bus_start;
        write_byte({MY_ADDR, 1'b0}, a);
        write_byte(8'h5A, a);
        chk("R5 ack before restart", 32'(a), 1);
        bus_start;
        chk("R2 restart ends session", 32'(stop_n - st0), 1);
        c0 = tx_cnt;
        write_byte({MY_ADDR, 1'b1}, a);
        chk("R2 restart address ack", 32'(a), 1);
        chk("R2 restart direction", 32'(last_dir), 1);
        read_byte(1'b0, d);
        chk("R7 read after restart", 32'(d), 32'(tx_pat(c0)));
        bus_stop;

        // Random sessions
        for (int k = 0; k < 8; k++) begin
            dir = 1'($urandom % 2);
            len = 1 + int'($urandom % 4);
            st0 = stop_n;
            if (!dir) begin
                r0 = rx_n;
                bus_start;
                write_byte({MY_ADDR, 1'b0}, a);
                chk("R4 rnd write addr ack", 32'(a), 1);
                for (int j = 0; j < len; j++) begin
                    d = 8'($urandom);
                    write_byte(d, a);
                    chk("R5 rnd write ack", 32'(a), 1);
                    chk("R3 rnd write data", 32'(rx_log[(r0 + j) % 64]), 32'(d));
                end
                bus_stop;
                chk("R2 rnd write stop", 32'(stop_n - st0), 1);
            end else begin
                c0 = tx_cnt;
                bus_start;
                write_byte({MY_ADDR, 1'b1}, a);
                chk("R4 rnd read addr ack", 32'(a), 1);
                for (int j = 0; j < len; j++) begin
                    read_byte(j != len - 1, d);
                    chk("R7 rnd read data", 32'(d), 32'(tx_pat(c0 + j)));
                end
                chk("R8 rnd request count", 32'(tx_cnt - c0), 32'(len));
                bus_stop;
                chk("R8 rnd stop", 32'(stop_n - st0), 1);
            end
        end

        chk("R10 oe changed with SCL high", 32'(r10_viol), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule